// File: doc/BRIEF.md
# Prioritised interrupt vector sequencer

This block sits beside a processor core and decides when and where the core jumps on an interrupt. It gathers requests from a reset request line, a non-maskable pin, a maskable external pin and a parameterised set of peripheral lines. When an eligible request is pending, it waits for the core to report that the current instruction has finished. It then asks the core to save its registers, which is a plain request/done handshake. Once that is done, it reads a two-byte vector from memory and hands the resulting 16-bit handler address to the core as a program-counter load.

Each source's vector sits at a table base plus twice the source index. The base is an input, so the whole table can be moved, for example from a top-of-memory location to a RAM copy. A vector holds the handler's address with the high byte at the lower address. The block keeps the global mask flag. Entering any handler sets the flag. A return-from-interrupt strobe clears it, and explicit set and clear strobes from the core also change it. Reset requests skip the boundary wait and the stacking handshake.

Top module: `irq_vector_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, the mask flag i_flag_o is 1 and stack_req_o, mem_rd_o and pc_load_o are 0.
- R2: A non-reset request causes stack_req_o to rise only in the cycle after a cycle with boundary_i high. A request is not taken while boundary_i stays low.
- R3: stack_req_o stays high until stack_done_i is seen high. The first vector read is issued in the cycle after that.
- R4: The vector fetch is two reads on consecutive cycles, first at address V and then at V+1. Read data returns in the cycle after each read. pc_load_o pulses in the cycle after the second read, with pc_o = {byte at V, byte at V+1}.
- R5: V = vec_base_i + 2 × index. The indices are: reset request 0, non-maskable pin 1, maskable pin 2, peripheral k is 3+k. svc_id_o carries the index during pc_load_o.
- R6: Among eligible pending sources, the lowest index is serviced first.
- R7: The maskable pin and the peripheral lines are taken only while i_flag_o is 0. With the flag at 1 they produce no stack_req_o.
- R8: A rising edge on nmi_i latches a request that is taken whatever the mask flag is. Holding nmi_i high does not request again.
- R9: i_flag_o is 1 from the first vector read of any entry through pc_load_o. rti_i or imask_clr_i clears it, and imask_set_i sets it. Entry takes precedence over the strobes, and setting takes precedence over clearing.
- R10: A rising edge on rst_req_i is taken from idle or waiting without boundary_i and without stack_req_o. It sets the mask flag and fetches the vector at vec_base_i + 0.
- R11: Requests pending at the same time are serviced one after another. A maskable request that is still pending waits during a handler and is taken after rti_i clears the flag and the next boundary arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req_i | input | 1 | Reset request, rising edge latched |
| nmi_i | input | 1 | Non-maskable pin, rising edge latched |
| irq_i | input | 1 | Maskable external pin, level request |
| periph_req_i | input | NPER | Peripheral level requests, bit k is index 3+k |
| boundary_i | input | 1 | Current instruction has completed |
| stack_req_o | output | 1 | Request to save core registers |
| stack_done_i | input | 1 | Register save finished |
| rti_i | input | 1 | Return from interrupt, clears the mask flag |
| imask_set_i | input | 1 | Set the mask flag |
| imask_clr_i | input | 1 | Clear the mask flag |
| vec_base_i | input | AW | Vector table base address |
| mem_rd_o | output | 1 | Byte read strobe |
| mem_addr_o | output | AW | Byte read address |
| mem_rdata_i | input | AW/2 | Read data, valid the cycle after mem_rd_o |
| pc_load_o | output | 1 | Load pc_o into the program counter |
| pc_o | output | AW | Handler address |
| svc_id_o | output | clog2(NPER+3) | Index of the source being entered |
| i_flag_o | output | 1 | Global mask flag |

## Verification
The assertions take several things for granted about the environment. Memory returns data exactly one cycle after a read. stack_done_i is raised only while stack_req_o is high. Peripheral and maskable levels stay up until their handler is entered. rti_i does not coincide with an entry. The bench drives every input half a cycle away from the sampling edge. It answers a stack request with a one-cycle done only after seeing the request, and it serves memory from a registered model. It drops request levels and strobes the return only after a handler has been entered, so one row of stimulus never leaks into the next.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_STACK = 3'd2,
    ST_FHI   = 3'd3,
    ST_FLO   = 3'd4,
    ST_LOAD  = 3'd5
  } seq_state_t;

  localparam int unsigned IDX_RST = 0;
  localparam int unsigned IDX_NMI = 1;
  localparam int unsigned IDX_IRQ = 2;
  localparam int unsigned IDX_PER0 = 3;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pin_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise = pin_i & ~pin_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (rise)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  assert_edge_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_i && !pin_q) |=> pend_q);

  assert_level_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q && pin_i && !pend_q) |=> !pend_q || $rose(pin_q));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC = 7,
  localparam int unsigned IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic            i_flag_i,
  output logic            any_o,
  output logic [IDXW-1:0] grant_o
);
  logic [NSRC-1:0] elig;

  assign elig = pend_i & {{(NSRC-2){~i_flag_i}}, 2'b11};

  always_comb begin
    any_o   = 1'b0;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any_o   = 1'b1;
        grant_o = IDXW'(i);
      end
    end
  end

  assert_masked_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_flag_i && !pend_i[0] && !pend_i[1]) |-> !any_o);

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i[1] && !pend_i[0]) |-> (any_o && grant_o == IDXW'(1)));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irqseq_pkg::*;
#(
  parameter int unsigned IDXW = 3,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_i,
  input  logic [IDXW-1:0] grant_i,
  input  logic            rst_pend_i,
  input  logic            boundary_i,
  input  logic            stack_done_i,
  input  logic            rti_i,
  input  logic            imask_set_i,
  input  logic            imask_clr_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            stack_req_o,
  output logic            mem_rd_o,
  output logic            addr_lo_o,
  output logic [IDXW-1:0] sel_o,
  output logic            pc_load_o,
  output logic [2*DW-1:0] pc_o,
  output logic            i_flag_o,
  output logic            clr_rst_o,
  output logic            clr_nmi_o
);
  seq_state_t      st_q, st_d;
  logic [IDXW-1:0] sel_q, sel_d;
  logic [DW-1:0]   hi_q;
  logic            hi_en;
  logic            i_q, i_d;
  logic            set_entry;

  always_comb begin
    st_d      = st_q;
    sel_d     = sel_q;
    clr_rst_o = 1'b0;
    clr_nmi_o = 1'b0;
    set_entry = 1'b0;
    case (st_q)
      ST_IDLE, ST_WAIT: begin
        if (rst_pend_i) begin
          st_d      = ST_FHI;
          sel_d     = IDXW'(IDX_RST);
          clr_rst_o = 1'b1;
          set_entry = 1'b1;
        end else if (any_i && boundary_i) begin
          st_d      = ST_STACK;
          sel_d     = grant_i;
          clr_nmi_o = (grant_i == IDXW'(IDX_NMI));
        end else if (any_i) begin
          st_d = ST_WAIT;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_STACK: begin
        if (stack_done_i) begin
          st_d      = ST_FHI;
          set_entry = 1'b1;
        end
      end
      ST_FHI:  st_d = ST_FLO;
      ST_FLO:  st_d = ST_LOAD;
      ST_LOAD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    i_d = i_q;
    if (rti_i || imask_clr_i) i_d = 1'b0;
    if (imask_set_i)          i_d = 1'b1;
    if (set_entry)            i_d = 1'b1;
  end

  assign hi_en = (st_q == ST_FLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      i_q   <= 1'b1;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      i_q   <= i_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= mem_rdata_i;
    end
  end

  assign stack_req_o = (st_q == ST_STACK);
  assign mem_rd_o    = (st_q == ST_FHI) || (st_q == ST_FLO);
  assign addr_lo_o   = (st_q == ST_FLO);
  assign pc_load_o   = (st_q == ST_LOAD);
  assign pc_o        = {hi_q, mem_rdata_i};
  assign sel_o       = sel_q;
  assign i_flag_o    = i_q;

  assert_wait_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_req_o) |-> $past(boundary_i));

  assert_stack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_req_o && !stack_done_i) |=> stack_req_o);

  assert_fetch_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_req_o && stack_done_i) |=> mem_rd_o);

  assert_two_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> ($past(mem_rd_o) && $past(mem_rd_o, 2)));

  assert_entry_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || pc_load_o) |-> i_flag_o);

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stack_req_o) && sel_q >= IDXW'(IDX_IRQ)) |-> $past(!i_flag_o));

  assert_rti_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && !imask_set_i && st_q == ST_IDLE && !rst_pend_i) |=> !i_flag_o);

  assert_reset_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend_i && (st_q == ST_IDLE || st_q == ST_WAIT)) |=> (mem_rd_o && !stack_req_o));

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int unsigned NPER = 4,
  parameter int unsigned AW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rst_req_i,
  input  logic                         nmi_i,
  input  logic                         irq_i,
  input  logic [NPER-1:0]              periph_req_i,
  input  logic                         boundary_i,
  output logic                         stack_req_o,
  input  logic                         stack_done_i,
  input  logic                         rti_i,
  input  logic                         imask_set_i,
  input  logic                         imask_clr_i,
  input  logic [AW-1:0]                vec_base_i,
  output logic                         mem_rd_o,
  output logic [AW-1:0]                mem_addr_o,
  input  logic [AW/2-1:0]              mem_rdata_i,
  output logic                         pc_load_o,
  output logic [AW-1:0]                pc_o,
  output logic [$clog2(NPER+3)-1:0]    svc_id_o,
  output logic                         i_flag_o
);
  localparam int unsigned NSRC = NPER + 3;
  localparam int unsigned IDXW = $clog2(NSRC);
  localparam int unsigned DW   = AW / 2;
  localparam int unsigned NEDGE = 2;

  logic [NEDGE-1:0] edge_pin;
  logic [NEDGE-1:0] edge_clr;
  logic [NEDGE-1:0] edge_pend;
  logic [NSRC-1:0]  pend;
  logic             any;
  logic [IDXW-1:0]  grant;
  logic [IDXW-1:0]  sel;
  logic             addr_lo;
  logic             clr_rst;
  logic             clr_nmi;

  assign edge_pin = {nmi_i, rst_req_i};
  assign edge_clr = {clr_nmi, clr_rst};

  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    irq_edge_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (edge_pin[g]),
      .clr_i  (edge_clr[g]),
      .pend_o (edge_pend[g])
    );
  end

  assign pend = {periph_req_i, irq_i, edge_pend};

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .i_flag_i (i_flag_o),
    .any_o    (any),
    .grant_o  (grant)
  );

  irq_seq_fsm #(.IDXW(IDXW), .DW(DW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_i        (any),
    .grant_i      (grant),
    .rst_pend_i   (edge_pend[0]),
    .boundary_i   (boundary_i),
    .stack_done_i (stack_done_i),
    .rti_i        (rti_i),
    .imask_set_i  (imask_set_i),
    .imask_clr_i  (imask_clr_i),
    .mem_rdata_i  (mem_rdata_i),
    .stack_req_o  (stack_req_o),
    .mem_rd_o     (mem_rd_o),
    .addr_lo_o    (addr_lo),
    .sel_o        (sel),
    .pc_load_o    (pc_load_o),
    .pc_o         (pc_o),
    .i_flag_o     (i_flag_o),
    .clr_rst_o    (clr_rst),
    .clr_nmi_o    (clr_nmi)
  );

  assign mem_addr_o = vec_base_i + {{(AW-IDXW-1){1'b0}}, sel, addr_lo};
  assign svc_id_o   = sel;

  assert_lo_follows_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  assert_vec_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !$past(mem_rd_o)) |-> (mem_addr_o[0] == vec_base_i[0]));

endmodule

// File: tb/test_irq_vector_seq.sv
module test_irq_vector_seq;
  localparam int NPER = 4;
  localparam int AW = 16;
  localparam int NONE = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0, nmi = 1'b0, irq = 1'b0;
  logic [NPER-1:0] per = '0;
  logic boundary = 1'b0, stack_done = 1'b0, rti = 1'b0;
  logic iset = 1'b0, iclr = 1'b0;
  logic [AW-1:0] base = 16'hFF80;
  logic stack_req, mem_rd, pc_load, iflag;
  logic [AW-1:0] mem_addr, pc;
  logic [7:0] rdata = 8'h00;
  logic [2:0] svc;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_seq #(.NPER(NPER), .AW(AW)) i_irq_vector_seq (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_i(nmi), .irq_i(irq),
    .periph_req_i(per), .boundary_i(boundary), .stack_req_o(stack_req),
    .stack_done_i(stack_done), .rti_i(rti), .imask_set_i(iset), .imask_clr_i(iclr),
    .vec_base_i(base), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .pc_load_o(pc_load), .pc_o(pc), .svc_id_o(svc), .i_flag_o(iflag)
  );

  function automatic logic [7:0] fb(input logic [15:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h29;
  endfunction

  always @(posedge clk) if (mem_rd) rdata <= fb(mem_addr);

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_rti();
    rti = 1'b1; tick(1); rti = 1'b0; tick(1);
  endtask

  task automatic run_service(input int exp, input string tag);
    bit seen = 0;
    logic [15:0] pcv = '0, vec;
    logic [2:0] sv = '0;
    for (int cyc = 0; cyc < 30 && !seen; cyc++) begin
      @(negedge clk);
      boundary = (cyc == 2);
      stack_done = stack_req;
      if (pc_load) begin seen = 1; pcv = pc; sv = svc; end
    end
    boundary = 1'b0; stack_done = 1'b0;
    if (exp == NONE) begin
      check(!seen, {tag, " R7 no entry"}, {31'd0, seen}, 0);
    end else begin
      vec = base + 16'(exp * 2);
      check(seen, {tag, " R4 entry seen"}, {31'd0, seen}, 1);
      check(pcv == {fb(vec), fb(vec + 16'd1)}, {tag, " R4 R5 pc"}, pcv, {fb(vec), fb(vec + 16'd1)});
      check(sv == 3'(exp), {tag, " R5 R6 svc"}, sv, exp);
      check(iflag, {tag, " R9 flag set on entry"}, iflag, 1);
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    bit bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (stack_req || mem_rd || pc_load) bad = 1;
      boundary = (k % 3 == 1);
    end
    boundary = 1'b0;
    check(!bad, tag, {31'd0, bad}, 0);
  endtask

  // {rst, nmi, irq, per[3:0], iclr, base[15:0], exp[2:0]}
  localparam logic [26:0] TBL [9] = '{
    {1'b0, 1'b0, 1'b1, 4'b0000, 1'b1, 16'hFF80, 3'd2},
    {1'b0, 1'b0, 1'b0, 4'b0001, 1'b1, 16'hFF80, 3'd3},
    {1'b0, 1'b0, 1'b0, 4'b1010, 1'b1, 16'h3E00, 3'd4},
    {1'b0, 1'b0, 1'b1, 4'b1111, 1'b1, 16'hFF80, 3'd2},
    {1'b0, 1'b1, 1'b1, 4'b0000, 1'b1, 16'h3E00, 3'd1},
    {1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 16'hFF80, 3'd1},
    {1'b0, 1'b0, 1'b1, 4'b0110, 1'b0, 16'hFF80, 3'd7},
    {1'b1, 1'b0, 1'b1, 4'b0011, 1'b1, 16'h3E40, 3'd0},
    {1'b0, 1'b0, 1'b0, 4'b1000, 1'b1, 16'h0100, 3'd6}
  };

  initial begin
    tick(3);
    // R1 reset state, during reset and first cycle after release
    check(iflag && !stack_req && !mem_rd && !pc_load, "R1 in reset", {iflag, stack_req, mem_rd, pc_load}, 4'b1000);
    rst_n = 1'b1;
    tick(1);
    check(iflag && !stack_req && !mem_rd && !pc_load, "R1 after release", {iflag, stack_req, mem_rd, pc_load}, 4'b1000);

    // Table walk: R4 R5 R6 R7 R8 R10
    for (int r = 0; r < 9; r++) begin
      iset = 1'b1; tick(1); iset = 1'b0;
      if (TBL[r][19]) begin iclr = 1'b1; tick(1); iclr = 1'b0; end
      base = TBL[r][18:3];
      irq = TBL[r][24];
      per = TBL[r][23:20];
      rst_req = TBL[r][26];
      nmi = TBL[r][25];
      tick(1);
      rst_req = 1'b0; nmi = 1'b0;
      run_service(int'(TBL[r][2:0]), $sformatf("row %0d", r));
      irq = 1'b0; per = '0;
      tick(1);
      pulse_rti();
      tick(2);
    end

    // R2 / R3 / R4 / R9 directed timing
    base = 16'hFF80;
    iclr = 1'b1; tick(1); iclr = 1'b0;
    check(!iflag, "R9 clear strobe", iflag, 0);
    irq = 1'b1;
    expect_none_noboundary();
    boundary = 1'b1; tick(1); boundary = 1'b0;
    check(stack_req, "R2 stack after boundary", stack_req, 1);
    begin
      bit held = 1;
      for (int k = 0; k < 5; k++) begin tick(1); if (!stack_req || mem_rd) held = 0; end
      check(held, "R3 stack request held", held, 1);
    end
    stack_done = 1'b1; tick(1); stack_done = 1'b0;
    check(mem_rd && mem_addr == 16'hFF84, "R3 R4 first read addr", {mem_rd, mem_addr}, {1'b1, 16'hFF84});
    check(iflag, "R9 flag set at fetch", iflag, 1);
    tick(1);
    check(mem_rd && mem_addr == 16'hFF85, "R4 second read addr", {mem_rd, mem_addr}, {1'b1, 16'hFF85});
    tick(1);
    check(pc_load && pc == {fb(16'hFF84), fb(16'hFF85)}, "R4 pc load", pc, {fb(16'hFF84), fb(16'hFF85)});
    irq = 1'b0;
    tick(1);
    pulse_rti();
    check(!iflag, "R9 rti clears flag", iflag, 0);

    // R8 held NMI taken with mask set, not retaken
    iset = 1'b1; tick(1); iset = 1'b0;
    nmi = 1'b1;
    run_service(1, "nmi held R8");
    pulse_rti();
    expect_none(15, "R8 held level no retake");
    nmi = 1'b0;
    iset = 1'b1; tick(1); iset = 1'b0;

    // R11 back-to-back service in order
    iclr = 1'b1; tick(1); iclr = 1'b0;
    nmi = 1'b1; per = 4'b0010; tick(1); nmi = 1'b0;
    run_service(1, "R11 first");
    expect_none(8, "R11 maskable waits in handler R7");
    pulse_rti();
    run_service(4, "R11 second");
    per = '0;
    pulse_rti();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic expect_none_noboundary();
    bit bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (stack_req || mem_rd) bad = 1;
    end
    check(!bad, "R2 no entry without boundary", {31'd0, bad}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule